// File: doc/BRIEF.md
# Serially Programmed Transmit Beamforming Pulse Generator

This block drives the logic-level transmit enables of a multi-channel ultrasound array. A complete firing profile arrives as one serial bit stream. It holds a start delay and a pulse width for every channel, plus one burst length and one receive-gain code that all channels share. The stream is collected in a shadow shift register. It becomes the active profile only when its leading header field reads all ones.

After the block is armed, a fire strobe starts a shared 11-bit timebase. This timebase is a 6-bit coarse counter running down from all ones, paired with a 5-bit fine counter. Each channel waits until the timebase equals its own delay. The channel then emits a burst of equal-width pulses with equal gaps and drops low after its last pulse. A done flag rises once every channel has finished.

A new packet may be shifted in while a firing is still running. It is held frozen in the shadow register and takes effect as soon as the firing ends, so the next profile is ready without dead time.

Top module: `txbf_pulse_gen`

## Requirements
- R1: While reset is asserted and directly after it, all `tx_o` bits, `armed_o`, `done_o` and `rx_gain_o` are zero.
- R2: A packet is `16 + 16*NCH` bits, one bit per clock with `sdat_vld_i` high, MSB first, in this order:
  - a 6-bit header;
  - 5 spare bits, which are ignored;
  - a 3-bit burst field (pulses per firing = field + 1);
  - a 2-bit gain code;
  - one 16-bit word per channel, channel 0 first.
  In each channel word, bits 15:5 are the start delay in ticks and bits 4:0 are the pulse width minus one.
- R3: If the header of a completed packet is 111111 and no firing is running, the cycle after the last bit shows `armed_o` high and `rx_gain_o` equal to the packet's gain code.
- R4: If the header of a completed packet is anything other than 111111, `armed_o` drops low the next cycle, and `fire_i` then produces no pulses.
- R5: `fire_i` is accepted only while armed and idle. A channel with delay D first drives `tx_o` high D+1 cycles after the accepting clock edge.
- R6: Each pulse is W+1 cycles high and is followed by a W+1 cycle low gap, where W is the width field. The channel emits burst-field+1 pulses, then stays low.
- R7: `done_o` is cleared when a fire is accepted. It rises two cycles after the latest channel's last high cycle. A `fire_i` pulse during a running firing is ignored.
- R8: A high `frame_clr_i` discards any partially shifted packet and restarts bit counting.
- R9: A good packet that completes during a firing is frozen. Extra serial bits are ignored, and `rx_gain_o` and `armed_o` keep their values until the firing ends. The new profile appears one cycle after `done_o` rises.
- R10: A `fire_i` that falls in the same cycle as a profile transfer is ignored.
- R11: The largest delay, 2047 ticks, fires correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Tick clock, one tick per timebase step |
| rst_ni | input | 1 | Asynchronous active-low reset |
| frame_clr_i | input | 1 | Discards a partial packet |
| sdat_i | input | 1 | Serial profile bit |
| sdat_vld_i | input | 1 | `sdat_i` holds a valid bit this cycle |
| fire_i | input | 1 | Starts a firing |
| tx_o | output | NCH | Per-channel transmit pulse enable |
| armed_o | output | 1 | A valid profile is active |
| done_o | output | 1 | All channels have finished the last firing |
| rx_gain_o | output | 2 | Receive gain step code |

## Verification
Two pairs of events can meet in one cycle, and both are driven on purpose.

The first pair is a packet's last bit and the end of a firing. The bench shifts a second profile while a long firing is running. It checks that the gain code keeps its old value while the packet is frozen, that the new value appears exactly one cycle after `done_o` rises, and that extra bits sent after the packet leave the next firing's waveform unchanged.

The second pair is a fire strobe and a profile transfer. The bench raises `fire_i` together with a packet's last bit. It then requires that no output moves and `done_o` stays high, followed by a normal firing that matches the new profile cycle by cycle.

// File: rtl/txbf_pkg.sv
package txbf_pkg;

   // per-channel burst sequencer state
   typedef enum logic [2:0] {
      CH_IDLE = 3'd0,
      CH_WAIT = 3'd1,
      CH_HIGH = 3'd2,
      CH_LOW  = 3'd3,
      CH_FIN  = 3'd4
   } ch_state_t;

endpackage

// File: rtl/txbf_loader.sv
module txbf_loader #(
   parameter int NCH    = 64,
   parameter int DLY_W  = 11,
   parameter int WID_W  = 5,
   parameter int CNT_W  = 3,
   parameter int GAIN_W = 2,
   parameter int HDR_W  = 6,
   parameter int SPR_W  = 5
) (
   input  logic                            clk_i,
   input  logic                            rst_ni,
   input  logic                            clr_i,
   input  logic                            sdat_i,
   input  logic                            vld_i,
   input  logic                            busy_i,
   output logic                            arm_o,
   output logic                            xfer_o,
   output logic [GAIN_W-1:0]               gain_o,
   output logic [CNT_W-1:0]                npls_o,
   output logic [NCH-1:0][DLY_W-1:0]       dly_o,
   output logic [NCH-1:0][WID_W-1:0]       wid_o
);

   localparam int CHW      = DLY_W + WID_W;
   localparam int CTL_W    = HDR_W + SPR_W + CNT_W + GAIN_W;
   localparam int PKT_W    = CTL_W + NCH * CHW;
   localparam int BC_W     = $clog2(PKT_W + 1);
   localparam int CNT_LSB  = PKT_W - HDR_W - SPR_W - CNT_W;
   localparam int GAIN_LSB = CNT_LSB - GAIN_W;

   logic [PKT_W-1:0] sh_q, sh_nxt, src;
   logic [BC_W-1:0]  bcnt_q;
   logic             hold_q, arm_q;
   logic             shift_ok, last, hdr_ok, xfer;
   logic [GAIN_W-1:0] gain_q;
   logic [CNT_W-1:0]  npls_q;

   assign shift_ok = vld_i && !hold_q && !clr_i;
   assign last     = shift_ok && (bcnt_q == BC_W'(PKT_W - 1));
   assign sh_nxt   = {sh_q[PKT_W-2:0], sdat_i};
   assign hdr_ok   = &sh_nxt[PKT_W-1 -: HDR_W];
   assign xfer     = (last && hdr_ok && !busy_i) || (hold_q && !busy_i);
   assign src      = hold_q ? sh_q : sh_nxt;

   // shadow register and bit counter
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sh_q   <= '0;
         bcnt_q <= '0;
      end else if (clr_i && !hold_q) begin
         sh_q   <= '0;
         bcnt_q <= '0;
      end else if (shift_ok) begin
         sh_q   <= sh_nxt;
         bcnt_q <= last ? '0 : bcnt_q + 1'b1;
      end
   end

   // freeze while a firing is running, arm state
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         hold_q <= 1'b0;
         arm_q  <= 1'b0;
      end else begin
         if (last && hdr_ok && busy_i) hold_q <= 1'b1;
         else if (hold_q && !busy_i)   hold_q <= 1'b0;
         if (xfer)                     arm_q  <= 1'b1;
         else if (last && !hdr_ok)     arm_q  <= 1'b0;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         gain_q <= '0;
         npls_q <= '0;
      end else if (xfer) begin
         gain_q <= src[GAIN_LSB +: GAIN_W];
         npls_q <= src[CNT_LSB +: CNT_W];
      end
   end

   for (genvar g = 0; g < NCH; g++) begin : g_word
      localparam int WLSB = CHW * (NCH - 1 - g);
      logic [DLY_W-1:0] d_q;
      logic [WID_W-1:0] w_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            d_q <= '0;
            w_q <= '0;
         end else if (xfer) begin
            d_q <= src[WLSB + WID_W +: DLY_W];
            w_q <= src[WLSB +: WID_W];
         end
      end
      assign dly_o[g] = d_q;
      assign wid_o[g] = w_q;
   end

   assign arm_o  = arm_q;
   assign xfer_o = xfer;
   assign gain_o = gain_q;
   assign npls_o = npls_q;

endmodule

// File: rtl/txbf_timebase.sv
module txbf_timebase #(
   parameter int DLY_W = 11,
   parameter int CRS_W = 6
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic                    start_i,
   input  logic                    run_i,
   output logic [CRS_W-1:0]        coarse_o,
   output logic [DLY_W-CRS_W-1:0]  fine_o
);

   localparam int FIN_W = DLY_W - CRS_W;

   logic [CRS_W-1:0] crs_q;
   logic [FIN_W-1:0] fin_q;
   logic             at_end, fin_wrap;

   assign at_end   = (crs_q == '0) && (&fin_q);
   assign fin_wrap = &fin_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         crs_q <= '1;
         fin_q <= '0;
      end else if (start_i) begin
         crs_q <= '1;
         fin_q <= '0;
      end else if (run_i && !at_end) begin
         fin_q <= fin_q + 1'b1;
         if (fin_wrap) crs_q <= crs_q - 1'b1;
      end
   end

   assign coarse_o = crs_q;
   assign fine_o   = fin_q;

endmodule

// File: rtl/txbf_channel.sv
module txbf_channel
   import txbf_pkg::*;
#(
   parameter int DLY_W = 11,
   parameter int CRS_W = 6,
   parameter int WID_W = 5,
   parameter int CNT_W = 3
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic                    start_i,
   input  logic                    run_i,
   input  logic [CRS_W-1:0]        coarse_i,
   input  logic [DLY_W-CRS_W-1:0]  fine_i,
   input  logic [DLY_W-1:0]        dly_i,
   input  logic [WID_W-1:0]        wid_i,
   input  logic [CNT_W-1:0]        npls_i,
   output logic                    tx_o,
   output logic                    fin_o
);

   localparam int FIN_W = DLY_W - CRS_W;

   ch_state_t        st_q;
   logic [WID_W-1:0] ph_q;
   logic [CNT_W-1:0] n_q;
   logic             hit;

   // coarse counter runs down, so its complement is the elapsed coarse count
   assign hit = run_i && (coarse_i == ~dly_i[DLY_W-1 -: CRS_W])
                      && (fine_i == dly_i[FIN_W-1:0]);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q <= CH_IDLE;
         ph_q <= '0;
         n_q  <= '0;
      end else if (start_i) begin
         st_q <= CH_WAIT;
         ph_q <= '0;
         n_q  <= '0;
      end else begin
         unique case (st_q)
            CH_WAIT: if (hit) begin
               st_q <= CH_HIGH;
               ph_q <= '0;
            end
            CH_HIGH: if (ph_q == wid_i) begin
               ph_q <= '0;
               st_q <= (n_q == npls_i) ? CH_FIN : CH_LOW;
            end else begin
               ph_q <= ph_q + 1'b1;
            end
            CH_LOW: if (ph_q == wid_i) begin
               ph_q <= '0;
               n_q  <= n_q + 1'b1;
               st_q <= CH_HIGH;
            end else begin
               ph_q <= ph_q + 1'b1;
            end
            default: ;
         endcase
      end
   end

   assign tx_o  = (st_q == CH_HIGH);
   assign fin_o = (st_q == CH_FIN);

endmodule

// File: rtl/txbf_pulse_gen.sv
module txbf_pulse_gen #(
   parameter int NCH    = 64,
   parameter int DLY_W  = 11,
   parameter int CRS_W  = 6,
   parameter int WID_W  = 5,
   parameter int CNT_W  = 3,
   parameter int GAIN_W = 2,
   parameter int HDR_W  = 6,
   parameter int SPR_W  = 5
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              frame_clr_i,
   input  logic              sdat_i,
   input  logic              sdat_vld_i,
   input  logic              fire_i,
   output logic [NCH-1:0]    tx_o,
   output logic              armed_o,
   output logic              done_o,
   output logic [GAIN_W-1:0] rx_gain_o
);

   localparam int FIN_W = DLY_W - CRS_W;

   if (NCH < 1) begin : g_bad_nch
      $error("txbf_pulse_gen: NCH must be at least 1");
   end
   if (CRS_W < 1 || CRS_W >= DLY_W) begin : g_bad_split
      $error("txbf_pulse_gen: coarse width must lie inside the delay width");
   end
   if (HDR_W < 1) begin : g_bad_hdr
      $error("txbf_pulse_gen: header must have at least one bit");
   end

   logic                       busy_q, done_q, xfer, arm, accept, all_fin;
   logic [CNT_W-1:0]           npls;
   logic [NCH-1:0][DLY_W-1:0]  dly;
   logic [NCH-1:0][WID_W-1:0]  wid;
   logic [CRS_W-1:0]           coarse;
   logic [FIN_W-1:0]           fine;
   logic [NCH-1:0]             fin_v;

   txbf_loader #(
      .NCH(NCH), .DLY_W(DLY_W), .WID_W(WID_W), .CNT_W(CNT_W),
      .GAIN_W(GAIN_W), .HDR_W(HDR_W), .SPR_W(SPR_W)
   ) u_loader (
      .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(frame_clr_i),
      .sdat_i(sdat_i), .vld_i(sdat_vld_i), .busy_i(busy_q),
      .arm_o(arm), .xfer_o(xfer), .gain_o(rx_gain_o), .npls_o(npls),
      .dly_o(dly), .wid_o(wid)
   );

   assign accept  = fire_i && arm && !busy_q && !xfer;
   assign all_fin = &fin_v;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
      end else if (accept) begin
         busy_q <= 1'b1;
         done_q <= 1'b0;
      end else if (busy_q && all_fin) begin
         busy_q <= 1'b0;
         done_q <= 1'b1;
      end
   end

   txbf_timebase #(.DLY_W(DLY_W), .CRS_W(CRS_W)) u_tb (
      .clk_i(clk_i), .rst_ni(rst_ni), .start_i(accept), .run_i(busy_q),
      .coarse_o(coarse), .fine_o(fine)
   );

   for (genvar g = 0; g < NCH; g++) begin : g_ch
      txbf_channel #(
         .DLY_W(DLY_W), .CRS_W(CRS_W), .WID_W(WID_W), .CNT_W(CNT_W)
      ) u_ch (
         .clk_i(clk_i), .rst_ni(rst_ni), .start_i(accept), .run_i(busy_q),
         .coarse_i(coarse), .fine_i(fine), .dly_i(dly[g]), .wid_i(wid[g]),
         .npls_i(npls), .tx_o(tx_o[g]), .fin_o(fin_v[g])
      );
   end

   assign armed_o = arm;
   assign done_o  = done_q;

endmodule

// File: rtl/txbf_pulse_gen_chk.sv
module txbf_pulse_gen_chk #(
   parameter int NCH    = 64,
   parameter int GAIN_W = 2
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic [NCH-1:0]    tx_i,
   input logic              armed_i,
   input logic              done_i,
   input logic [GAIN_W-1:0] gain_i,
   input logic              busy_i,
   input logic              xfer_i
);

   // R1
   reset_quiet_chk: assert property (@(posedge clk_i)
      !rst_ni |=> (tx_i == '0 && !armed_i && !done_i));

   // R5
   fire_needs_arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(busy_i) |-> $past(armed_i));

   // R6
   idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !busy_i |-> tx_i == '0);

   // R7
   done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_i |-> !busy_i);

   // R10
   xfer_blocks_fire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      xfer_i |=> !busy_i);

   // R9
   gain_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_i |=> $stable(gain_i));

endmodule

bind txbf_pulse_gen txbf_pulse_gen_chk #(.NCH(NCH), .GAIN_W(GAIN_W)) u_chk (
   .clk_i(clk_i), .rst_ni(rst_ni), .tx_i(tx_o), .armed_i(armed_o),
   .done_i(done_o), .gain_i(rx_gain_o), .busy_i(busy_q), .xfer_i(xfer)
);

// File: tb/test_txbf_pulse_gen.sv
module test_txbf_pulse_gen;

   localparam int NCH   = 8;
   localparam int PKT_W = 16 + 16 * NCH;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           frame_clr = 1'b0, sdat = 1'b0, sdat_vld = 1'b0, fire = 1'b0;
   logic [NCH-1:0] tx;
   logic           armed, done;
   logic [1:0]     gain;

   int n_chk = 0, n_fail = 0;
   int pd[2][NCH];
   int pw[2][NCH];
   int pc[2];
   int pg[2];

   always #5 clk = ~clk;

   txbf_pulse_gen #(.NCH(NCH)) i_txbf_pulse_gen (
      .clk_i(clk), .rst_ni(rst_n), .frame_clr_i(frame_clr), .sdat_i(sdat),
      .sdat_vld_i(sdat_vld), .fire_i(fire), .tx_o(tx), .armed_o(armed),
      .done_o(done), .rx_gain_o(gain)
   );

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
   endtask

   task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                      input logic [63:0] expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
      end
   endtask

   function automatic logic [NCH-1:0] exp_vec(int s, int j);
      logic [NCH-1:0] v;
      for (int c = 0; c < NCH; c++) begin
         int w1  = pw[s][c] + 1;
         int rel = j - pd[s][c] - 1;
         v[c] = (rel >= 0) && (rel < (2 * (pc[s] + 1) - 1) * w1)
                && ((rel % (2 * w1)) < w1);
      end
      return v;
   endfunction

   task automatic rand_prof(input int s, input int maxd);
      for (int c = 0; c < NCH; c++) begin
         pd[s][c] = $urandom % (maxd + 1);
         pw[s][c] = $urandom % 32;
      end
      pc[s] = $urandom % 8;
      pg[s] = $urandom % 4;
   endtask

   task automatic put_bit(input logic b);
      sdat = b;
      sdat_vld = 1'b1;
      @(negedge clk);
   endtask

   // R2 packet layout: header, spare, burst, gain, channel words
   task automatic send_pkt(input int s, input bit bad, input bit fire_last,
                           input int extra, input bit chk_arm);
      logic [PKT_W-1:0] v;
      v = '0;
      v[PKT_W-1 -: 6]  = bad ? 6'b111011 : 6'b111111;
      v[PKT_W-7 -: 5]  = 5'($urandom);
      v[PKT_W-12 -: 3] = 3'(pc[s]);
      v[PKT_W-15 -: 2] = 2'(pg[s]);
      for (int c = 0; c < NCH; c++)
         v[16 * (NCH - 1 - c) +: 16] = {11'(pd[s][c]), 5'(pw[s][c])};
      for (int i = PKT_W - 1; i >= 0; i--) begin
         if (i == 0 && fire_last) fire = 1'b1;
         put_bit(v[i]);
      end
      fire = 1'b0;
      for (int i = 0; i < extra; i++) put_bit(1'($urandom));
      sdat_vld = 1'b0;
      if (chk_arm) begin
         chk(armed == !bad, bad ? "R4 armed after bad header" : "R3 armed",
             64'(armed), 64'(!bad));
         if (!bad) chk(gain == 2'(pg[s]), "R3 gain code", 64'(gain), 64'(pg[s]));
      end
   endtask

   task automatic run_fire(input int s, input bit refire);
      int m = 0;
      for (int c = 0; c < NCH; c++) begin
         int e = pd[s][c] + (2 * (pc[s] + 1) - 1) * (pw[s][c] + 1);
         if (e > m) m = e;
      end
      fire = 1'b1;
      @(negedge clk);
      fire = 1'b0;
      for (int j = 0; j <= m + 2; j++) begin
         if (refire && j == 3) fire = 1'b1;
         if (j == 4) fire = 1'b0;
         if (j == 0) chk(!done, "R7 done cleared on fire", 64'(done), 64'd0);
         chk(tx == exp_vec(s, j), "R5/R6 pulse pattern", 64'(tx), 64'(exp_vec(s, j)));
         if (j == m + 1) chk(!done, "R7 done not early", 64'(done), 64'd0);
         if (j == m + 2) chk(done, "R7 done rises", 64'(done), 64'd1);
         @(negedge clk);
      end
   endtask

   task automatic expect_quiet(input int n, input string tag);
      for (int j = 0; j < n; j++) begin
         chk(tx == '0 && done, tag, {63'(tx), done}, 64'd1);
         @(negedge clk);
      end
   endtask

   initial begin
      #(10 * 190000);
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (4) @(negedge clk);
      chk(tx == '0 && !armed && !done && gain == '0, "R1 reset state",
          {59'(tx), armed, done, gain}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(tx == '0 && !armed && !done, "R1 after reset", {61'(tx), armed, done}, 64'd0);

      // R5 fire before any profile is ignored
      fire = 1'b1;
      @(negedge clk);
      fire = 1'b0;
      repeat (5) begin
         chk(tx == '0 && !done, "R5 fire while unarmed", 64'(tx), 64'd0);
         @(negedge clk);
      end

      // random profiles, R7 refire on odd rounds
      for (int r = 0; r < 5; r++) begin
         rand_prof(0, 150);
         send_pkt(0, 1'b0, 1'b0, 0, 1'b1);
         run_fire(0, r[0]);
      end

      // R11 largest delay next to zero delay and longest burst
      rand_prof(0, 60);
      pd[0][0] = 0;       pw[0][0] = 0;
      pd[0][NCH-1] = 2047; pw[0][NCH-1] = 31;
      pc[0] = 7;
      send_pkt(0, 1'b0, 1'b0, 0, 1'b1);
      run_fire(0, 1'b0);

      // R4 bad header disarms and fire does nothing
      send_pkt(0, 1'b1, 1'b0, 0, 1'b1);
      fire = 1'b1;
      @(negedge clk);
      fire = 1'b0;
      expect_quiet(30, "R4 no pulses after bad header");

      // R8 partial packet discarded by frame clear
      for (int i = 0; i < 37; i++) put_bit(1'($urandom));
      sdat_vld = 1'b0;
      frame_clr = 1'b1;
      @(negedge clk);
      frame_clr = 1'b0;
      rand_prof(0, 100);
      send_pkt(0, 1'b0, 1'b0, 0, 1'b1);
      chk(armed, "R8 packet after clear accepted", 64'(armed), 64'd1);
      run_fire(0, 1'b0);

      // R10 fire together with the transfer is ignored
      rand_prof(0, 100);
      send_pkt(0, 1'b0, 1'b1, 0, 1'b1);
      expect_quiet(20, "R10 fire on transfer ignored");
      run_fire(0, 1'b0);

      // R9 packet completes during a running firing
      rand_prof(0, 200);
      pd[0][1] = 450;
      rand_prof(1, 100);
      pg[1] = (pg[0] + 1) % 4;
      send_pkt(0, 1'b0, 1'b0, 0, 1'b1);
      fork
         run_fire(0, 1'b0);
         begin
            repeat (5) @(negedge clk);
            send_pkt(1, 1'b0, 1'b0, 10, 1'b0);
            chk(gain == 2'(pg[0]) && armed, "R9 gain frozen while firing",
                64'(gain), 64'(pg[0]));
         end
      join
      chk(gain == 2'(pg[1]) && armed, "R9 new gain after done", 64'(gain), 64'(pg[1]));
      run_fire(1, 1'b0);

      summary();
      $finish;
   end

endmodule